// File: doc/BRIEF.md
# Operating-Point Search Controller

This block is a hardware sequencer that searches for the most aggressive safe operating point on one axis while the other axis stays fixed. In frequency mode it looks for the highest clock code that still passes at the present supply. In voltage mode it looks for the lowest supply code that still passes at the present clock. It starts at the least stressed code and writes the chosen control register. It then waits for the clock generator to re-lock or for the regulator to acknowledge the new command, launches an external test and samples its verdict. After each pass it moves one code further.

The search ends on the first failing test, on a test that never reports back, or on a lock or acknowledge that never arrives. In every case the register is reloaded with the last code that passed, and the result is then pulled back by one code as a safety margin. A hang also raises a one-cycle recovery interrupt. On completion a countdown is loaded with a caller-supplied interval, and its expiry signals that the search should run again.

Top module: `oppt_search`

## Requirements
- R1: Both control registers reset to code 0. Code k means 1.6 GHz + k x 100 MHz on the clock axis and 1.1 V - k x 55 mV on the supply axis. A start pulse in idle latches mode_i (0 = clock, 1 = supply), writes code 0 to the selected register and leaves the other register unchanged. Start and mode are ignored while busy_o is high.
- R2: Every change of fcr_o pulses pll_relock_o for exactly one cycle. In clock mode, test_start_o is raised only after pll_lock_i has been sampled high in a cycle after the relock pulse.
- R3: Every change of vcr_o raises vid_req_o from the next cycle, and it stays high until vid_ack_i is sampled high. In supply mode a test is launched only when no command is pending. A supply search never pulses pll_relock_o.
- R4: A pass on a code below NUM_CODES-1 advances the selected register by exactly one code and starts a new wait-and-test round. The register never rises by more than one code at a time.
- R5: A failing verdict ends the search. In the next cycle the selected register holds the last passing code.
- R6: If test_done_i is not seen within TEST_CYC+1 cycles of test_start_o, the register is reloaded with the last passing code (0 if none) and recov_irq_o pulses for one cycle.
- R7: If the lock (clock mode) or the acknowledge (supply mode) does not arrive within LOCK_CYC+1 cycles of entering the wait, the same restore and interrupt as in R6 take place.
- R8: One cycle after the restore, or after a pass on the top code, the register takes the last passing code minus one, clamped at 0. At the same time done_o pulses for one cycle and busy_o falls. A search in which every code passes therefore ends on NUM_CODES-2.
- R9: err_o is set together with done_o when no test passed. It stays set until the next accepted start clears it.
- R10: done_o loads the interval N from reeval_ivl_i. reeval_due_o pulses for one cycle exactly N cycles after done_o. N = 0 gives no pulse, and the pulse never occurs while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (accepted only in idle) |
| mode_i | input | 1 | Axis select: 0 clock, 1 supply |
| reeval_ivl_i | input | REEVAL_W | Cycles until the next re-evaluation request |
| pll_lock_i | input | 1 | Clock generator locked |
| vid_ack_i | input | 1 | Regulator accepted the supply command |
| test_done_i | input | 1 | Test verdict valid |
| test_pass_i | input | 1 | Test verdict: 1 pass |
| fcr_o | output | CODE_W | Clock control code |
| vcr_o | output | CODE_W | Supply control code |
| pll_relock_o | output | 1 | One-cycle re-lock request on clock code change |
| vid_req_o | output | 1 | Supply command pending |
| test_start_o | output | 1 | One-cycle test launch |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle search complete |
| err_o | output | 1 | Last search had no passing code |
| recov_irq_o | output | 1 | One-cycle hang recovery interrupt |
| reeval_due_o | output | 1 | One-cycle re-evaluation request |

## Verification
The bench builds the block with five codes, LOCK_CYC = 8, TEST_CYC = 12 and an 8-bit interval. These short timeouts let both hang paths, the stuck lock and the silent test, expire within a few dozen cycles. With five codes, the top-of-range clamp and the all-pass result are reached in short runs. The small interval allows the timing of the re-evaluation pulse to be measured exactly. Runs cover a limit in the middle of the range, the full range, a fail on the first code, the supply axis, both hang kinds and a start that arrives while a search is in progress.

// File: rtl/oppt_pkg.sv
package oppt_pkg;

    localparam int unsigned NUM_AXES = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_RDY = 2'd1,
        ST_WAIT_RES = 2'd2,
        ST_FINISH   = 2'd3
    } srch_state_e;

    typedef enum logic {
        AX_FREQ = 1'b0,
        AX_VOLT = 1'b1
    } axis_e;

    // one-cycle strobes leaving the controller
    typedef struct packed {
        logic relock;
        logic tstart;
        logic done;
        logic irq;
    } strobe_t;

    // final applied code: one step back from the last pass, floored at zero
    function automatic int unsigned guard_code(int unsigned good, logic good_vld);
        if (!good_vld || good == 0) return 0;
        return good - 1;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/oppt_timer.sv
module oppt_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         fire_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fire_o <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= load_val_i;
            fire_o <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
            fire_o <= (cnt_q == W'(1));
        end else begin
            fire_o <= 1'b0;
        end
    end

    // R6
    fire_after_count_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> !$past(load_i));

endmodule

// File: rtl/oppt_code_reg.sv
module oppt_code_reg #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (we_i) q_o <= d_i;
    end

endmodule

// File: rtl/oppt_search.sv
module oppt_search
    import oppt_pkg::*;
#(
    parameter int unsigned NUM_CODES = 5,
    parameter int unsigned LOCK_CYC  = 64,
    parameter int unsigned TEST_CYC  = 4096,
    parameter int unsigned REEVAL_W  = 32,
    localparam int unsigned CODE_W   = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [REEVAL_W-1:0] reeval_ivl_i,
    input  logic                pll_lock_i,
    input  logic                vid_ack_i,
    input  logic                test_done_i,
    input  logic                test_pass_i,
    output logic [CODE_W-1:0]   fcr_o,
    output logic [CODE_W-1:0]   vcr_o,
    output logic                pll_relock_o,
    output logic                vid_req_o,
    output logic                test_start_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic                recov_irq_o,
    output logic                reeval_due_o
);

    localparam int unsigned WD_MAX = max_u(LOCK_CYC, TEST_CYC);
    localparam int unsigned WD_W   = $clog2(WD_MAX + 1);
    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(NUM_CODES - 1);

    srch_state_e st_q, st_d;
    axis_e       axis_q, axis_d;
    logic [CODE_W-1:0] good_q, good_d;
    logic        good_vld_q, good_vld_d;
    logic        err_q, err_d;
    logic        vid_req_q, vid_req_d;
    strobe_t     stb_q, stb_d;

    logic [CODE_W-1:0] code_q [NUM_AXES];
    logic [CODE_W-1:0] cur_code, restore_val, wr_val;
    logic        wr_en;
    axis_e       wr_axis;
    logic        wd_load, wd_fire, rc_load, rc_fire, hang, ready;
    logic [WD_W-1:0]     wd_val;
    logic [REEVAL_W-1:0] rc_val;

    // per-axis control registers
    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        oppt_code_reg #(.W(CODE_W)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .we_i (wr_en && (int'(wr_axis) == a)),
            .d_i  (wr_val),
            .q_o  (code_q[a])
        );
    end

    oppt_timer #(.W(WD_W)) u_wdog (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wd_load),
        .load_val_i (wd_val),
        .fire_o     (wd_fire)
    );

    oppt_timer #(.W(REEVAL_W)) u_reeval (
        .clk        (clk),
        .rst        (rst),
        .load_i     (rc_load),
        .load_val_i (rc_val),
        .fire_o     (rc_fire)
    );

    assign cur_code    = code_q[axis_q];
    assign restore_val = good_vld_q ? good_q : '0;
    assign ready       = (axis_q == AX_FREQ) ? (pll_lock_i && !stb_q.relock) : !vid_req_q;

    always_comb begin
        st_d       = st_q;
        axis_d     = axis_q;
        good_d     = good_q;
        good_vld_d = good_vld_q;
        err_d      = err_q;
        stb_d      = '0;
        wr_en      = 1'b0;
        wr_axis    = axis_q;
        wr_val     = cur_code;
        wd_load    = 1'b0;
        wd_val     = WD_W'(LOCK_CYC);
        rc_load    = 1'b0;
        rc_val     = reeval_ivl_i;
        hang       = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    axis_d     = axis_e'(mode_i);
                    wr_en      = 1'b1;
                    wr_axis    = axis_e'(mode_i);
                    wr_val     = '0;
                    good_vld_d = 1'b0;
                    err_d      = 1'b0;
                    wd_load    = 1'b1;
                    rc_load    = 1'b1;
                    rc_val     = '0;
                    st_d       = ST_WAIT_RDY;
                end
            end
            ST_WAIT_RDY: begin
                if (ready) begin
                    stb_d.tstart = 1'b1;
                    wd_load      = 1'b1;
                    wd_val       = WD_W'(TEST_CYC);
                    st_d         = ST_WAIT_RES;
                end else if (wd_fire) begin
                    hang = 1'b1;
                end
            end
            ST_WAIT_RES: begin
                if (test_done_i) begin
                    if (test_pass_i) begin
                        good_d     = cur_code;
                        good_vld_d = 1'b1;
                        if (cur_code == TOP_CODE) begin
                            st_d = ST_FINISH;
                        end else begin
                            wr_en   = 1'b1;
                            wr_val  = cur_code + 1'b1;
                            wd_load = 1'b1;
                            st_d    = ST_WAIT_RDY;
                        end
                    end else begin
                        wr_en  = 1'b1;
                        wr_val = restore_val;
                        st_d   = ST_FINISH;
                    end
                end else if (wd_fire) begin
                    hang = 1'b1;
                end
            end
            ST_FINISH: begin
                wr_en      = 1'b1;
                wr_val     = CODE_W'(guard_code(32'(good_q), good_vld_q));
                err_d      = !good_vld_q;
                stb_d.done = 1'b1;
                rc_load    = 1'b1;
                st_d       = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase

        if (hang) begin
            wr_en     = 1'b1;
            wr_val    = restore_val;
            stb_d.irq = 1'b1;
            st_d      = ST_FINISH;
        end

        stb_d.relock = wr_en && (wr_axis == AX_FREQ) && (wr_val != code_q[0]);

        if (wr_en && (wr_axis == AX_VOLT) && (wr_val != code_q[1])) vid_req_d = 1'b1;
        else if (vid_req_q && vid_ack_i)                             vid_req_d = 1'b0;
        else                                                         vid_req_d = vid_req_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            axis_q     <= AX_FREQ;
            good_q     <= '0;
            good_vld_q <= 1'b0;
            err_q      <= 1'b0;
            vid_req_q  <= 1'b0;
            stb_q      <= '0;
        end else begin
            st_q       <= st_d;
            axis_q     <= axis_d;
            good_q     <= good_d;
            good_vld_q <= good_vld_d;
            err_q      <= err_d;
            vid_req_q  <= vid_req_d;
            stb_q      <= stb_d;
        end
    end

    assign fcr_o        = code_q[0];
    assign vcr_o        = code_q[1];
    assign pll_relock_o = stb_q.relock;
    assign vid_req_o    = vid_req_q;
    assign test_start_o = stb_q.tstart;
    assign busy_o       = (st_q != ST_IDLE);
    assign done_o       = stb_q.done;
    assign err_o        = err_q;
    assign recov_irq_o  = stb_q.irq;
    assign reeval_due_o = rc_fire;

    // R2
    lock_before_test_chk: assert property (@(posedge clk) disable iff (rst)
        (test_start_o && axis_q == AX_FREQ) |-> $past(pll_lock_i));

    // R3
    cmd_clear_before_test_chk: assert property (@(posedge clk) disable iff (rst)
        (test_start_o && axis_q == AX_VOLT) |-> !$past(vid_req_o));

    // R1
    idle_axis_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && axis_q == AX_FREQ) |=> $stable(vcr_o));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && (fcr_o > $past(fcr_o))) |-> (fcr_o == $past(fcr_o) + 1'b1));

    // R6
    irq_needs_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        recov_irq_o |-> ($past(wd_fire) && $past(busy_o)));

    // R10
    due_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        reeval_due_o |-> !busy_o);

endmodule

// File: tb/oppt_search_test.sv
module oppt_search_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NC = 5, LCK = 8, TST = 12, RW = 8;
    localparam int LOCK_DLY = 3, ACK_DLY = 2, TEST_DLY = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, mode_i = 1'b0;
    logic [RW-1:0] reeval_ivl_i = '0;
    logic pll_lock_i = 1'b1, vid_ack_i = 1'b0, test_done_i = 1'b0, test_pass_i = 1'b0;
    logic [2:0] fcr_o, vcr_o;
    logic pll_relock_o, vid_req_o, test_start_o, busy_o, done_o, err_o, recov_irq_o, reeval_due_o;

    always #2 clk = ~clk;

    oppt_search #(.NUM_CODES(NC), .LOCK_CYC(LCK), .TEST_CYC(TST), .REEVAL_W(RW)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .reeval_ivl_i(reeval_ivl_i),
        .pll_lock_i(pll_lock_i), .vid_ack_i(vid_ack_i), .test_done_i(test_done_i),
        .test_pass_i(test_pass_i), .fcr_o(fcr_o), .vcr_o(vcr_o), .pll_relock_o(pll_relock_o),
        .vid_req_o(vid_req_o), .test_start_o(test_start_o), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .recov_irq_o(recov_irq_o), .reeval_due_o(reeval_due_o)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int irq_seen = 0, relock_seen = 0, due_seen = 0, done_cyc = -1, due_cyc = -1;
    int cfg_lim = -1, cfg_hang = -1, cfg_stuck = -1, cfg_mode = 0;
    int lcnt = 0, acnt = 0, tcnt = 0, tcode = 0;
    bit live = 0;

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference
    int m_st, m_ax, m_code[2], m_good, m_gv, m_rel, m_ts, m_done, m_err, m_irq, m_vreq;
    int m_wd, m_wdf, m_rc, m_rcf;

    always @(posedge clk) begin : ref_model
        int wr, wax, wv, wl, wlv, rl, rlv, nst, rdy, hng, n_ax, n_good, n_gv, n_err;
        if (rst) begin
            m_st = 0; m_ax = 0; m_code[0] = 0; m_code[1] = 0; m_good = 0; m_gv = 0;
            m_rel = 0; m_ts = 0; m_done = 0; m_err = 0; m_irq = 0; m_vreq = 0;
            m_wd = 0; m_wdf = 0; m_rc = 0; m_rcf = 0;
            live = 1;
        end else begin
            wr = 0; wax = m_ax; wv = 0; wl = 0; wlv = LCK; rl = 0; rlv = 0; nst = m_st; hng = 0;
            n_ax = m_ax; n_good = m_good; n_gv = m_gv; n_err = m_err;
            m_ts = 0; m_done = 0; m_irq = 0;
            rdy = (m_ax == 0) ? (pll_lock_i && !m_rel) : !m_vreq;
            case (m_st)
                0: if (start_i) begin
                    n_ax = int'(mode_i); wr = 1; wax = n_ax; wv = 0; n_gv = 0; n_err = 0;
                    wl = 1; wlv = LCK; rl = 1; rlv = 0; nst = 1;
                end
                1: if (rdy) begin m_ts = 1; wl = 1; wlv = TST; nst = 2; end
                   else if (m_wdf != 0) hng = 1;
                2: if (test_done_i) begin
                       if (test_pass_i) begin
                           n_good = m_code[m_ax]; n_gv = 1;
                           if (m_code[m_ax] == NC - 1) nst = 3;
                           else begin wr = 1; wv = m_code[m_ax] + 1; wl = 1; wlv = LCK; nst = 1; end
                       end else begin wr = 1; wv = m_gv ? m_good : 0; nst = 3; end
                   end else if (m_wdf != 0) hng = 1;
                default: begin
                    wr = 1; wv = (m_gv != 0 && m_good > 0) ? m_good - 1 : 0;
                    n_err = (m_gv == 0); m_done = 1; rl = 1; rlv = int'(reeval_ivl_i); nst = 0;
                end
            endcase
            if (hng) begin wr = 1; wv = m_gv ? m_good : 0; m_irq = 1; nst = 3; end
            m_rel = (wr != 0 && wax == 0 && wv != m_code[0]);
            if (wr != 0 && wax == 1 && wv != m_code[1]) m_vreq = 1;
            else if (m_vreq != 0 && vid_ack_i) m_vreq = 0;
            if (wl != 0) begin m_wd = wlv; m_wdf = 0; end
            else if (m_wd > 0) begin m_wdf = (m_wd == 1); m_wd--; end
            else m_wdf = 0;
            if (rl != 0) begin m_rc = rlv; m_rcf = 0; end
            else if (m_rc > 0) begin m_rcf = (m_rc == 1); m_rc--; end
            else m_rcf = 0;
            if (wr != 0) m_code[wax] = wv;
            m_st = nst; m_ax = n_ax; m_good = n_good; m_gv = n_gv; m_err = n_err;
        end
    end

    // compare, monitor, environment responders, watchdog
    always @(negedge clk) begin
        cyc++;
        if (live) begin
            check("R4", "fcr_o", int'(fcr_o), m_code[0]);
            check("R1", "vcr_o", int'(vcr_o), m_code[1]);
            check("R2", "pll_relock_o", int'(pll_relock_o), m_rel);
            check("R3", "vid_req_o", int'(vid_req_o), m_vreq);
            check("R2", "test_start_o", int'(test_start_o), m_ts);
            check("R1", "busy_o", int'(busy_o), int'(m_st != 0));
            check("R8", "done_o", int'(done_o), m_done);
            check("R9", "err_o", int'(err_o), m_err);
            check("R6", "recov_irq_o", int'(recov_irq_o), m_irq);
            check("R10", "reeval_due_o", int'(reeval_due_o), m_rcf);
        end
        if (recov_irq_o) irq_seen++;
        if (pll_relock_o) relock_seen++;
        if (done_o) done_cyc = cyc;
        if (reeval_due_o) begin due_seen++; due_cyc = cyc; end
        if (pll_relock_o) begin pll_lock_i = 1'b0; lcnt = LOCK_DLY; end
        else if (lcnt > 0) begin
            lcnt--;
            if (lcnt == 0 && int'(fcr_o) != cfg_stuck) pll_lock_i = 1'b1;
        end
        if (vid_ack_i) vid_ack_i = 1'b0;
        else if (vid_req_o) begin
            acnt++;
            if (acnt >= ACK_DLY) begin vid_ack_i = 1'b1; acnt = 0; end
        end else acnt = 0;
        test_done_i = 1'b0;
        if (test_start_o) begin tcnt = TEST_DLY; tcode = (cfg_mode != 0) ? int'(vcr_o) : int'(fcr_o); end
        else if (tcnt > 0) begin
            tcnt--;
            if (tcnt == 0 && tcode != cfg_hang) begin
                test_done_i = 1'b1;
                test_pass_i = (tcode <= cfg_lim);
            end
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL R8 run did not finish actual=%0d expected=%0d", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run(int md, int lim, int hng, int stk, int ivl, bit poke,
                       string ctag, int e_fcr, int e_vcr, int e_err, string itag, int e_irq);
        @(negedge clk);
        cfg_mode = md; cfg_lim = lim; cfg_hang = hng; cfg_stuck = stk;
        reeval_ivl_i = RW'(ivl);
        irq_seen = 0; relock_seen = 0; due_seen = 0; done_cyc = -1; due_cyc = -1;
        start_i = 1'b1; mode_i = md[0];
        @(negedge clk);
        start_i = 1'b0;
        check("R9", "err_o cleared by start", int'(err_o), 0);
        check("R1", "busy_o after start", int'(busy_o), 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            start_i = 1'b1; mode_i = ~md[0];
            @(negedge clk);
            start_i = 1'b0; mode_i = md[0];
        end
        for (int i = 0; i < 2000 && done_cyc < 0; i++) @(negedge clk);
        check(ctag, "search completed", int'(done_cyc >= 0), 1);
        @(negedge clk);
        check(ctag, "final fcr_o", int'(fcr_o), e_fcr);
        check(ctag, "final vcr_o", int'(vcr_o), e_vcr);
        check("R9", "final err_o", int'(err_o), e_err);
        check(itag, "interrupt count", irq_seen, e_irq);
        if (md != 0) check("R3", "relock pulses in supply search", relock_seen, 0);
        repeat (ivl + 6) @(negedge clk);
        if (ivl == 0) check("R10", "no due with zero interval", due_seen, 0);
        else begin
            check("R10", "due count", due_seen, 1);
            check("R10", "due delay after done", due_cyc - done_cyc, ivl);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset fcr_o", int'(fcr_o), 0);
        check("R1", "reset vcr_o", int'(vcr_o), 0);
        check("R1", "reset busy_o", int'(busy_o), 0);
        // clock axis, limit at code 2, stray start mid-run: ends on 1
        run(0, 2, -1, -1, 0, 1'b1, "R5", 1, 0, 0, "R6", 0);
        // every code passes: clamp at top, back off to 3
        run(0, 4, -1, -1, 0, 1'b0, "R8", 3, 0, 0, "R6", 0);
        // first test fails: error, code 0
        run(0, -1, -1, -1, 0, 1'b0, "R9", 0, 0, 1, "R6", 0);
        // supply axis, limit 3: ends on 2, clock code untouched
        run(1, 3, -1, -1, 0, 1'b0, "R3", 0, 2, 0, "R6", 0);
        // silent test on code 3: restore 2, back off to 1
        run(0, 4, 3, -1, 0, 1'b0, "R6", 1, 2, 0, "R6", 1);
        // lock never arrives on code 2: restore 1, back off to 0
        run(0, 4, -1, 2, 0, 1'b0, "R7", 0, 2, 0, "R7", 1);
        // supply axis, silent first test: error and interrupt
        run(1, 4, 0, -1, 0, 1'b0, "R6", 0, 0, 1, "R6", 1);
        // re-evaluation interval
        run(0, 1, -1, -1, 5, 1'b0, "R10", 0, 0, 0, "R6", 0);
        run(0, 3, -1, -1, 9, 1'b0, "R4", 2, 0, 0, "R6", 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule